// File: doc/BRIEF.md
# Audio Transmit Sample FIFO with Width Alignment and Pair Draining

This block is the transmit sample path of an audio link controller. Software-side logic presents 32-bit sample writes. Each sample is left-justified into a 20-bit slot word according to the configured sample width. In compact mode a single write carries two 16-bit halves, and these become two slot words. The words are held in a FIFO of parameterised depth.

Once the FIFO is at least half full and transmit is enabled on an audio slot, it drains toward a downstream sink in left/right pairs over a valid/ready handshake. The sink can stall at any time. The block keeps four status flags: empty, half-empty, full and underrun. It derives three raw interrupt causes from them, and a mask reduces these to a single interrupt line.

A write that would overrun the FIFO is dropped. When a drain and a write fall in the same cycle, the drain is taken first, and the write's room check sees the level after the pair has left.

Top module: `stx_tx_path`

## Requirements
- R1: After reset, stEmpty and stHalfEmpty are 1, stFull and stUnderrun are 0, sinkValid is 0 and the FIFO holds no entries.
- R2: In non-compact mode each accepted write stores one slot word. The slot word is (wrData shifted left by S) masked to its low 20 bits, where cfgWidth 0 means 16-bit with S=4, 1 means 18-bit with S=2, 2 means 20-bit with S=0, and 3 means 12-bit with S=8.
- R3: In compact mode one write stores two slot words: first wrData[15:0], then wrData[31:16], each aligned by the R2 rule. Compact mode is ignored (one word per write) when cfgWidth is 1 or 2.
- R4: A one-word write is accepted only if the level (after any same-cycle drain) is below DEPTH. A two-word write is accepted only if that level plus 2 is below DEPTH. Any other write is dropped and leaves the FIFO unchanged.
- R5: After an accepted write, a nonzero level clears stEmpty and stUnderrun, a level of at least DEPTH/2 clears stHalfEmpty, and a level of DEPTH sets stFull.
- R6: sinkValid rises the cycle after cfgEnable is 1, cfgSlots is nonzero and the level is at least DEPTH/2. With cfgEnable 0 or cfgSlots 0 nothing is drained. sinkLeft carries the older entry of the head pair and sinkRight the next one.
- R7: Once started, draining continues one pair per accepted handshake while at least two entries remain. During a stall sinkValid, sinkLeft and sinkRight hold. A single leftover entry stays in the FIFO.
- R8: After a pair leaves, stFull clears, stHalfEmpty is set if the level is at most DEPTH/2, and stEmpty and stUnderrun are set if the level is zero.
- R9: irqRaw bit 0 is stUnderrun, bit 1 is stHalfEmpty, and bit 2 is stEmpty while sinkValid is 0. irqOut is 1 exactly when irqRaw ANDed with irqMask is nonzero.
- R10: A pulse on clrUnderrun clears stUnderrun. A drain that empties the FIFO in the same cycle sets it again.
- R11: With a drain and a write in the same cycle, the pair leaves first and the write's acceptance is judged on the reduced level, so a write into a full FIFO that is draining is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrValid | input | 1 | Sample write strobe |
| wrData | input | 32 | Sample write data |
| cfgWidth | input | 2 | Sample width code |
| cfgCompact | input | 1 | Two 16-bit samples per write |
| cfgEnable | input | 1 | Transmit enable |
| cfgSlots | input | 2 | Audio slot selection, nonzero permits draining |
| clrUnderrun | input | 1 | Clear underrun flag |
| irqMask | input | 3 | Interrupt enable mask |
| sinkValid | output | 1 | Pair available to sink |
| sinkReady | input | 1 | Sink accepts pair |
| sinkLeft | output | 20 | Left slot word |
| sinkRight | output | 20 | Right slot word |
| stEmpty | output | 1 | FIFO empty flag |
| stHalfEmpty | output | 1 | Half-empty flag |
| stFull | output | 1 | Full flag |
| stUnderrun | output | 1 | Underrun flag |
| irqRaw | output | 3 | Raw interrupt causes |
| irqOut | output | 1 | Masked interrupt line |

## Verification
Every width code is filled past full in non-compact mode and then drained, so each shift amount, the 20-bit mask and the dropped overrun write are all visible on the pair outputs. Compact writes are tried at both legal widths and at an illegal one; this separates half ordering, the level-plus-two room rule and the forced fallback. Drains run against a toggling sink, against a disabled slot selection and alongside continuous writes, including a write into a full FIFO that is draining. These runs show holding during a stall, the odd leftover and the drain-first ordering. A mask sweep over a known flag state covers every combination of the interrupt line.

// File: rtl/stx_pkg.sv
package stx_pkg;

  localparam int SLOT_W = 20;

  typedef struct packed {
    logic pop;      // a left/right pair leaves this cycle
    logic push;     // a write is stored this cycle
    logic pushTwo;  // the write stores two words (compact)
  } stxStrobe_t;

  function automatic logic [SLOT_W-1:0] alignSample(input logic [31:0] raw,
                                                     input logic [1:0] width);
    logic [31:0] shifted;
    case (width)
      2'd0:    shifted = raw << 4;
      2'd1:    shifted = raw << 2;
      2'd2:    shifted = raw;
      default: shifted = raw << 8;
    endcase
    return shifted[SLOT_W-1:0];
  endfunction

  function automatic logic compactAllowed(input logic [1:0] width);
    return (width == 2'd0) || (width == 2'd3);
  endfunction

endpackage

// File: rtl/stx_datapath.sv
module stx_datapath
  import stx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LVLW = $clog2(DEPTH + 1),
  localparam int PTRW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  stxStrobe_t        strobe,
  input  logic [31:0]       wrData,
  input  logic [1:0]        cfgWidth,
  output logic [LVLW-1:0]   level,
  output logic [SLOT_W-1:0] headLeft,
  output logic [SLOT_W-1:0] headRight
);

  logic [SLOT_W-1:0] store [DEPTH];
  logic [PTRW-1:0]   rdPtr;
  logic [PTRW-1:0]   wrPtr;
  logic [SLOT_W-1:0] wordLo;
  logic [SLOT_W-1:0] wordHi;

  always_comb begin
    wordLo = strobe.pushTwo ? alignSample({16'b0, wrData[15:0]}, cfgWidth)
                            : alignSample(wrData, cfgWidth);
    wordHi = alignSample({16'b0, wrData[31:16]}, cfgWidth);
  end

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      store[wrPtr] <= wordLo;
      if (strobe.pushTwo) store[PTRW'(wrPtr + 1'b1)] <= wordHi;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      level <= '0;
    end else begin
      if (strobe.pop) rdPtr <= PTRW'(rdPtr + 2'd2);
      if (strobe.push) wrPtr <= PTRW'(wrPtr + (strobe.pushTwo ? 2'd2 : 2'd1));
      level <= LVLW'(level
                     - (strobe.pop ? LVLW'(2) : LVLW'(0))
                     + (strobe.push ? (strobe.pushTwo ? LVLW'(2) : LVLW'(1)) : LVLW'(0)));
    end
  end

  assign headLeft  = store[rdPtr];
  assign headRight = store[PTRW'(rdPtr + 1'b1)];

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    level <= LVLW'(DEPTH)); // R4

  AST_POP_HAS_PAIR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> level >= LVLW'(2)); // R7

  AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.pop && level >= LVLW'(2)) |=> ($stable(headLeft) && $stable(headRight))); // R7

endmodule

// File: rtl/stx_control.sv
module stx_control
  import stx_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int LVLW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [LVLW-1:0] level,
  input  logic            wrValid,
  input  logic [1:0]      cfgWidth,
  input  logic            cfgCompact,
  input  logic            cfgEnable,
  input  logic [1:0]      cfgSlots,
  input  logic            clrUnderrun,
  input  logic            sinkReady,
  input  logic [2:0]      irqMask,
  output stxStrobe_t      strobe,
  output logic            sinkValid,
  output logic            stEmpty,
  output logic            stHalfEmpty,
  output logic            stFull,
  output logic            stUnderrun,
  output logic [2:0]      irqRaw,
  output logic            irqOut
);

  localparam int HALF = DEPTH / 2;

  logic            draining;
  logic            compactEff;
  logic            roomOk;
  logic [LVLW-1:0] lvlMid;
  logic [LVLW:0]   lvlNext;
  logic            emptyN, halfN, fullN, underN, drainN;

  always_comb begin
    strobe.pop     = draining && sinkReady;
    lvlMid         = level - (strobe.pop ? LVLW'(2) : LVLW'(0));
    compactEff     = cfgCompact && compactAllowed(cfgWidth);
    roomOk         = compactEff ? (({1'b0, lvlMid} + (LVLW+1)'(2)) < (LVLW+1)'(DEPTH))
                                : (lvlMid < LVLW'(DEPTH));
    strobe.push    = wrValid && roomOk;
    strobe.pushTwo = compactEff;
    lvlNext        = {1'b0, lvlMid}
                     + (strobe.push ? (compactEff ? (LVLW+1)'(2) : (LVLW+1)'(1)) : '0);

    emptyN = stEmpty;
    halfN  = stHalfEmpty;
    fullN  = stFull;
    underN = stUnderrun;
    if (clrUnderrun) underN = 1'b0;
    if (strobe.pop) begin
      fullN = 1'b0;
      if (lvlMid <= LVLW'(HALF)) halfN = 1'b1;
      if (lvlMid == '0) begin
        emptyN = 1'b1;
        underN = 1'b1;
      end
    end
    if (strobe.push) begin
      if (lvlNext != '0) begin
        emptyN = 1'b0;
        underN = 1'b0;
      end
      if (lvlNext >= (LVLW+1)'(HALF))  halfN = 1'b0;
      if (lvlNext >= (LVLW+1)'(DEPTH)) fullN = 1'b1;
    end
    drainN = cfgEnable && (|cfgSlots)
             && ((draining && lvlNext >= (LVLW+1)'(2)) || lvlNext >= (LVLW+1)'(HALF));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stEmpty     <= 1'b1;
      stHalfEmpty <= 1'b1;
      stFull      <= 1'b0;
      stUnderrun  <= 1'b0;
      draining    <= 1'b0;
    end else begin
      stEmpty     <= emptyN;
      stHalfEmpty <= halfN;
      stFull      <= fullN;
      stUnderrun  <= underN;
      draining    <= drainN;
    end
  end

  assign sinkValid = draining;
  assign irqRaw    = {stEmpty && !draining, stHalfEmpty, stUnderrun};
  assign irqOut    = |(irqRaw & irqMask);

  AST_EMPTY_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    stEmpty == (level == '0)); // R8

  AST_FULL_TRACK: assert property (@(posedge clk) disable iff (!rstN)
    stFull == (level == LVLW'(DEPTH))); // R5

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (sinkValid && !sinkReady && cfgEnable && (|cfgSlots)) |=> sinkValid); // R7

  AST_NO_DRAIN_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgEnable || cfgSlots == 2'b00) |=> !sinkValid); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !strobe.pop && level == LVLW'(DEPTH)) |=> level == $past(level)); // R4

endmodule

// File: rtl/stx_tx_path.sv
module stx_tx_path
  import stx_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrValid,
  input  logic [31:0] wrData,
  input  logic [1:0]  cfgWidth,
  input  logic        cfgCompact,
  input  logic        cfgEnable,
  input  logic [1:0]  cfgSlots,
  input  logic        clrUnderrun,
  input  logic [2:0]  irqMask,
  output logic        sinkValid,
  input  logic        sinkReady,
  output logic [19:0] sinkLeft,
  output logic [19:0] sinkRight,
  output logic        stEmpty,
  output logic        stHalfEmpty,
  output logic        stFull,
  output logic        stUnderrun,
  output logic [2:0]  irqRaw,
  output logic        irqOut
);

  localparam int LVLW = $clog2(DEPTH + 1);

  stxStrobe_t      strobe;
  logic [LVLW-1:0] level;

  stx_control #(.DEPTH(DEPTH)) i_control (
    .clk(clk), .rstN(rstN), .level(level), .wrValid(wrValid),
    .cfgWidth(cfgWidth), .cfgCompact(cfgCompact), .cfgEnable(cfgEnable),
    .cfgSlots(cfgSlots), .clrUnderrun(clrUnderrun), .sinkReady(sinkReady),
    .irqMask(irqMask), .strobe(strobe), .sinkValid(sinkValid),
    .stEmpty(stEmpty), .stHalfEmpty(stHalfEmpty), .stFull(stFull),
    .stUnderrun(stUnderrun), .irqRaw(irqRaw), .irqOut(irqOut)
  );

  stx_datapath #(.DEPTH(DEPTH)) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .cfgWidth(cfgWidth), .level(level), .headLeft(sinkLeft),
    .headRight(sinkRight)
  );

endmodule

// File: tb/test_stx_tx_path.sv
module test_stx_tx_path;

  localparam int DEPTH = 8;
  localparam int HALF  = DEPTH / 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrValid = 1'b0;
  logic [31:0] wrData = '0;
  logic [1:0]  cfgWidth = '0;
  logic        cfgCompact = 1'b0;
  logic        cfgEnable = 1'b0;
  logic [1:0]  cfgSlots = '0;
  logic        clrUnderrun = 1'b0;
  logic [2:0]  irqMask = '0;
  logic        sinkReady = 1'b0;
  logic        sinkValid;
  logic [19:0] sinkLeft, sinkRight;
  logic        stEmpty, stHalfEmpty, stFull, stUnderrun;
  logic [2:0]  irqRaw;
  logic        irqOut;

  stx_tx_path #(.DEPTH(DEPTH)) i_stx_tx_path (
    .clk(clk), .rstN(rstN), .wrValid(wrValid), .wrData(wrData),
    .cfgWidth(cfgWidth), .cfgCompact(cfgCompact), .cfgEnable(cfgEnable),
    .cfgSlots(cfgSlots), .clrUnderrun(clrUnderrun), .irqMask(irqMask),
    .sinkValid(sinkValid), .sinkReady(sinkReady), .sinkLeft(sinkLeft),
    .sinkRight(sinkRight), .stEmpty(stEmpty), .stHalfEmpty(stHalfEmpty),
    .stFull(stFull), .stUnderrun(stUnderrun), .irqRaw(irqRaw), .irqOut(irqOut)
  );

  always #10 clk = ~clk;  // 50 MHz

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  string scen = "R2";

  // bench model
  logic [19:0] q [0:4095];
  int qHead = 0, qTail = 0;
  bit mEmpty = 1, mHalf = 1, mFull = 0, mUnder = 0, mDrain = 0;
  int pops = 0, accepted = 0;
  bit lastAccepted = 0;

  task automatic chk(input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic logic [19:0] align(input logic [31:0] d, input int w);
    int sh;
    sh = (w == 0) ? 4 : (w == 1) ? 2 : (w == 2) ? 0 : 8;
    return 20'((d << sh) & 32'h000F_FFFF);
  endfunction

  // one clock: check outputs against model, drive inputs, update model
  task automatic cycle(input bit doWr, input logic [31:0] d, input bit rdy, input bit clr);
    bit pop, cEff, ok;
    int lvl, mid, lvlN;
    bit [2:0] raw;
    raw = {mEmpty && !mDrain, mHalf, mUnder};
    chk(stEmpty, mEmpty, "R1/R5/R8 stEmpty");
    chk(stHalfEmpty, mHalf, "R1/R5/R8 stHalfEmpty");
    chk(stFull, mFull, "R1/R5/R8 stFull");
    chk(stUnderrun, mUnder, "R1/R8/R10 stUnderrun");
    chk(sinkValid, mDrain, "R6/R7 sinkValid");
    chk(irqRaw, raw, "R9 irqRaw");
    chk(irqOut, |(raw & irqMask), "R9 irqOut");
    pop = mDrain && rdy;
    lvl = qTail - qHead;
    if (pop) begin
      chk(sinkLeft, q[qHead], {scen, " R6 sinkLeft"});
      chk(sinkRight, q[qHead + 1], {scen, " R6 sinkRight"});
    end
    wrValid = doWr;
    wrData = d;
    sinkReady = rdy;
    clrUnderrun = clr;
    if (clr) mUnder = 0;
    mid = lvl;
    if (pop) begin
      qHead += 2;
      pops++;
      mid = lvl - 2;
      mFull = 0;
      if (mid <= HALF) mHalf = 1;
      if (mid == 0) begin mEmpty = 1; mUnder = 1; end
    end
    cEff = cfgCompact && (cfgWidth == 0 || cfgWidth == 3);
    ok = cEff ? (mid + 2 < DEPTH) : (mid < DEPTH);
    lastAccepted = doWr && ok;
    if (doWr && ok) begin
      accepted++;
      if (cEff) begin
        q[qTail] = align({16'b0, d[15:0]}, int'(cfgWidth));
        q[qTail + 1] = align({16'b0, d[31:16]}, int'(cfgWidth));
        qTail += 2;
      end else begin
        q[qTail] = align(d, int'(cfgWidth));
        qTail += 1;
      end
    end
    lvlN = qTail - qHead;
    if (doWr && ok) begin
      if (lvlN > 0) begin mEmpty = 0; mUnder = 0; end
      if (lvlN >= HALF) mHalf = 0;
      if (lvlN >= DEPTH) mFull = 1;
    end
    mDrain = cfgEnable && (cfgSlots != 0) && ((mDrain && lvlN >= 2) || lvlN >= HALF);
    @(posedge clk);
    @(negedge clk);
    wrValid = 0;
    clrUnderrun = 0;
  endtask

  function automatic logic [31:0] pat(input int i, input int w);
    return 32'h9ABC_D123 ^ (i * 32'h0105_0301) ^ (w * 32'h3377_1100);
  endfunction

  initial begin
    int p0, a0;
    irqMask = 3'b111;
    repeat (3) @(negedge clk);
    rstN = 1;
    // R1 reset state
    chk(stEmpty, 1, "R1 reset empty");
    chk(stHalfEmpty, 1, "R1 reset halfEmpty");
    chk(stFull, 0, "R1 reset full");
    chk(sinkValid, 0, "R1 reset valid");

    // R2 / R4: every width, non-compact, fill past full then drain
    for (int w = 0; w < 4; w++) begin
      scen = "R2";
      cfgWidth = 2'(w); cfgCompact = 0; cfgEnable = 0; cfgSlots = 2'b01;
      for (int i = 0; i < DEPTH + 1; i++) cycle(1, pat(i, w), 0, 0);
      chk(stFull, 1, "R5 full after fill");
      p0 = pops;
      cfgEnable = 1;
      for (int i = 0; i < 8; i++) cycle(0, 0, 1, 0);
      chk(pops - p0, DEPTH / 2, "R4 overrun write dropped");
      chk(stUnderrun, 1, "R8 underrun on empty");
      cycle(0, 0, 1, 1);
      chk(stUnderrun, 0, "R10 underrun cleared");
      cfgEnable = 0;
    end

    // R3 compact at legal widths
    for (int k = 0; k < 2; k++) begin
      scen = "R3";
      cfgWidth = (k == 0) ? 2'd0 : 2'd3; cfgCompact = 1; cfgEnable = 0;
      for (int i = 0; i < 4; i++) cycle(1, pat(i + 20, k), 0, 0);
      p0 = pops;
      cfgEnable = 1;
      for (int i = 0; i < 6; i++) cycle(0, 0, 1, 0);
      chk(pops - p0, 3, "R4 compact room rule");
      cfgEnable = 0;
    end

    // R3 compact forced off at 18-bit
    scen = "R3";
    cfgWidth = 2'd1; cfgCompact = 1; cfgEnable = 1; cfgSlots = 2'b01;
    cycle(1, pat(40, 1), 1, 0);
    cycle(1, pat(41, 1), 1, 0);
    cycle(0, 0, 1, 0);
    chk(sinkValid, 0, "R3 one word per write");
    p0 = pops;
    cycle(1, pat(42, 1), 1, 0);
    cycle(1, pat(43, 1), 1, 0);
    for (int i = 0; i < 4; i++) cycle(0, 0, 1, 0);
    chk(pops - p0, 2, "R3 forced non-compact pairs");
    cfgCompact = 0;

    // R6 slot selection gates draining
    scen = "R6";
    cfgWidth = 2'd2; cfgEnable = 1; cfgSlots = 2'b00;
    for (int i = 0; i < 6; i++) cycle(1, pat(50 + i, 2), 1, 0);
    cycle(0, 0, 1, 0);
    chk(sinkValid, 0, "R6 no slot no drain");
    cfgSlots = 2'b10;
    for (int i = 0; i < 6; i++) cycle(0, 0, 1, 0);
    chk(stEmpty, 1, "R6 drained on slot select");

    // R7 stalls and odd leftover
    scen = "R7";
    cfgSlots = 2'b01;
    for (int i = 0; i < 5; i++) cycle(1, pat(60 + i, 2), 0, 0);
    p0 = pops;
    for (int i = 0; i < 10; i++) cycle(0, 0, (i % 2) == 1, 0);
    chk(pops - p0, 2, "R7 pairs under stall");
    chk(stEmpty, 0, "R7 leftover kept");
    chk(sinkValid, 0, "R7 stop below pair");
    for (int i = 0; i < 3; i++) cycle(1, pat(70 + i, 2), 0, 0);
    for (int i = 0; i < 6; i++) cycle(0, 0, 1, 0);
    chk(stEmpty, 1, "R7 leftover drained");

    // R11 concurrent writes and drains
    scen = "R11";
    cfgWidth = 2'd0;
    a0 = accepted;
    for (int i = 0; i < 20; i++) cycle(1, pat(80 + i, 0), 1, 0);
    chk(accepted - a0, 20, "R11 all accepted");
    for (int i = 0; i < 6; i++) cycle(0, 0, 1, 0);
    // write into full FIFO while draining
    cfgEnable = 0;
    for (int i = 0; i < 6; i++) cycle(0, 0, 1, 0);
    while (!stFull) cycle(1, pat(100 + qTail, 0), 0, 0);
    cfgEnable = 1;
    cycle(0, 0, 0, 0);
    cycle(1, pat(120, 0), 1, 0);
    chk(lastAccepted, 1, "R11 drain first frees room");
    for (int i = 0; i < 8; i++) cycle(0, 0, 1, 0);
    cfgEnable = 0;

    // R9 mask sweep
    if (!stEmpty) for (int i = 0; i < 4; i++) cycle(0, 0, 1, 0);
    for (int m = 0; m < 8; m++) begin
      irqMask = 3'(m);
      #1;
      chk(irqOut, |(irqRaw & 3'(m)), "R9 mask sweep line");
      cycle(0, 0, 0, 0);
    end

    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule